// File: doc/BRIEF.md
# ROM Signature Compaction Self-Test Controller

This controller tests a synchronous read-only memory without comparing words one at a time. After a start pulse it reads every address from the lowest to the highest, one read per clock. Each returned word is folded into a 64-bit multiple-input signature register. The signature held before a word is an input to that word's update, so the final value depends on every word and on the order in which the words arrive.

When the last word has been folded, the block reports a verdict by comparing the final signature with a golden value set by a parameter. The same signature can then be shifted out serially, most significant bit first, through a scan port, so that an external tester can inspect it. The memory array is not part of the block. The block drives the address and the active-low enable of the memory, and it takes the data word back after a fixed read latency.

Top module: `rom_sig_bist`

## Requirements
- R1: After reset, done_o, pass_o and fail_o are low, rom_cen_no is high, and scan_out_o is high, because the signature reset value is all ones.
- R2: When start_i is sampled high in the idle or done state, rom_cen_no goes low on the next cycle with rom_addr_o = 0. The address then rises by one every cycle up to DEPTH-1, and rom_cen_no returns high on the cycle after that last address.
- R3: The memory captures the address on the rising edge where rom_cen_no is low. The word is taken from rom_data_i on the edge that comes RD_LAT (default 2) cycles after the capture edge.
- R4: Starting a test loads the signature with all ones. Each word d updates the signature s to {s[62:0],1'b0} ^ (s[63] ? POLY : 0) ^ d, with POLY defaulting to 64'h1B.
- R5: done_o rises on the cycle after the last word is folded. It stays high until the next accepted start, and rom_cen_no stays high while done_o is high.
- R6: While done_o is high, exactly one of pass_o and fail_o is high. pass_o is high when the final signature equals EXP_SIG. The verdict does not change while the signature is shifted out. Both outputs are low while done_o is low.
- R7: Flipping any single bit of any memory word, or swapping two different words, makes fail_o high at the end of the test.
- R8: While done_o and scan_en_i are high, each rising edge of scan_clk_i, sampled on clk_i, shifts the signature left by one bit with a zero filled in. scan_out_o always shows the signature MSB.
- R9: Rising edges of scan_clk_i have no effect while scan_en_i is low or while a test is in progress.
- R10: A start_i pulse during a test in progress is ignored. The test runs to completion with an unchanged signature.
- R11: A start after done reseeds the signature and repeats the whole test, giving the same verdict for the same memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a test when idle or done |
| done_o | output | 1 | Test finished; verdict valid |
| pass_o | output | 1 | Final signature matched EXP_SIG |
| fail_o | output | 1 | Final signature differed from EXP_SIG |
| scan_clk_i | input | 1 | Scan shift strobe, sampled on clk_i |
| scan_en_i | input | 1 | Enables scan shifting |
| scan_out_o | output | 1 | Signature MSB |
| rom_addr_o | output | $clog2(DEPTH) | Memory address |
| rom_cen_no | output | 1 | Memory enable, active low |
| rom_data_i | input | DATA_W | Memory read data |

## Verification
On every cycle, the assertions check the following: the enable is low only while a test runs, consecutive reads step the address by one, the enable stays high once done, the verdict outputs are exclusive and appear only with done, and each scan shift moves bit 62 into the MSB. Other behaviours can only be shown by the bench's scenarios against its cycle model. These are that a single corrupted bit or a swapped word pair really flips the verdict, that the read latency lines up with the memory model, that a start during a test in progress is ignored, and that a repeated run reproduces the same signature.

// File: rtl/rom_sig_pkg.sv
package rom_sig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic vld;
    logic last;
  } rd_tag_t;

endpackage

// File: rtl/rom_sig_seq.sv
module rom_sig_seq
  import rom_sig_pkg::*;
#(
  parameter int DEPTH  = 4096,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cen_no,
  output logic              issue_last_o,
  output logic              launch_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = ADDR_W'(DEPTH - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cen_n_q;
  logic              at_max;

  assign at_max   = (addr_q == ADDR_MAX);
  assign launch_o = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cen_n_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (launch_o) begin
            state_q <= ST_RUN;
            addr_q  <= '0;
            cen_n_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (at_max) begin
            state_q <= ST_DRAIN;
            cen_n_q <= 1'b1;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (finish_i) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o       = addr_q;
  assign cen_no       = cen_n_q;
  assign issue_last_o = !cen_n_q && at_max;
  assign busy_o       = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done_o       = (state_q == ST_DONE);

  assert_cen_only_run_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !cen_n_q |-> (state_q == ST_RUN));

  assert_addr_step_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_q && $past(!cen_n_q)) |-> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/rom_sig_pipe.sv
module rom_sig_pipe
  import rom_sig_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  rd_tag_t tag_i,
  output rd_tag_t tag_o
);

  if (LAT == 0) begin : g_bypass
    assign tag_o = tag_i;
  end else begin : g_delay
    rd_tag_t stage_q [LAT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < LAT; i++) stage_q[i] <= '0;
      end else begin
        stage_q[0] <= tag_i;
        for (int i = 1; i < LAT; i++) stage_q[i] <= stage_q[i-1];
      end
    end

    assign tag_o = stage_q[LAT-1];

    assert_last_needs_vld_R3: assert property (
      @(posedge clk_i) disable iff (!rst_ni) tag_o.last |-> tag_o.vld);
  end

endmodule

// File: rtl/rom_sig_misr.sv
module rom_sig_misr #(
  parameter int              DATA_W  = 64,
  parameter logic [DATA_W-1:0] POLY    = 64'h1B,
  parameter logic [DATA_W-1:0] EXP_SIG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_i,
  input  logic              fold_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              match_o
);

  localparam logic [DATA_W-1:0] SEED = '1;

  logic [DATA_W-1:0] sig_q;
  logic [DATA_W-1:0] sig_nxt;
  logic              match_q;

  function automatic logic [DATA_W-1:0] misr_step(input logic [DATA_W-1:0] s,
                                                   input logic [DATA_W-1:0] d);
    return {s[DATA_W-2:0], 1'b0} ^ (s[DATA_W-1] ? POLY : '0) ^ d;
  endfunction

  assign sig_nxt = misr_step(sig_q, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q   <= SEED;
      match_q <= 1'b0;
    end else if (seed_i) begin
      sig_q   <= SEED;
      match_q <= 1'b0;
    end else if (fold_i) begin
      sig_q <= sig_nxt;
      if (last_i) match_q <= (sig_nxt == EXP_SIG);
    end else if (shift_i) begin
      sig_q <= {sig_q[DATA_W-2:0], 1'b0};
    end
  end

  assign msb_o   = sig_q[DATA_W-1];
  assign match_o = match_q;

  assert_shift_msb_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !seed_i && !fold_i) |=> (sig_q[DATA_W-1] == $past(sig_q[DATA_W-2])));

  assert_no_fold_in_scan_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !(shift_i && fold_i));

endmodule

// File: rtl/rom_sig_bist.sv
module rom_sig_bist
  import rom_sig_pkg::*;
#(
  parameter int                DEPTH   = 4096,
  parameter int                DATA_W  = 64,
  parameter int                RD_LAT  = 2,
  parameter logic [DATA_W-1:0] POLY    = 64'h1B,
  parameter logic [DATA_W-1:0] EXP_SIG = '0,
  localparam int               ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  input  logic              scan_clk_i,
  input  logic              scan_en_i,
  output logic              scan_out_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_cen_no,
  input  logic [DATA_W-1:0] rom_data_i
);

  logic    launch, busy, done, issue_last, finish, shift, match, scan_clk_q;
  rd_tag_t issue_tag, fold_tag;

  rom_sig_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .finish_i    (finish),
    .addr_o      (rom_addr_o),
    .cen_no      (rom_cen_no),
    .issue_last_o(issue_last),
    .launch_o    (launch),
    .busy_o      (busy),
    .done_o      (done)
  );

  assign issue_tag = '{vld: !rom_cen_no, last: issue_last};

  rom_sig_pipe #(.LAT(RD_LAT)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tag_i (issue_tag),
    .tag_o (fold_tag)
  );

  assign finish = fold_tag.vld && fold_tag.last;

  // scan strobe assumed slower than clk_i; rising edge detected here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_clk_q <= 1'b0;
    else         scan_clk_q <= scan_clk_i;
  end

  assign shift = done && scan_en_i && scan_clk_i && !scan_clk_q;

  rom_sig_misr #(
    .DATA_W (DATA_W),
    .POLY   (POLY),
    .EXP_SIG(EXP_SIG)
  ) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (launch),
    .fold_i (fold_tag.vld),
    .last_i (fold_tag.last),
    .data_i (rom_data_i),
    .shift_i(shift),
    .msb_o  (scan_out_o),
    .match_o(match)
  );

  assign done_o = done;
  assign pass_o = done && match;
  assign fail_o = done && !match;

  assert_verdict_excl_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> (done_o && !(pass_o && fail_o)));

  assert_quiet_when_done_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni) done_o |-> (rom_cen_no && !busy));

  assert_verdict_hold_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o) && !$past(launch)) |-> $stable(pass_o));

endmodule

// File: tb/test_rom_sig_bist.sv
module test_rom_sig_bist;

  localparam int          DEPTH  = 4096;
  localparam int          DATA_W = 64;
  localparam int          ADDR_W = 12;
  localparam logic [63:0] POLY   = 64'h1B;
  localparam logic [63:0] GOLD   = 64'h5A3C_96E1_0F87_D24B;
  localparam logic [63:0] SEED   = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, scan_clk = 1'b0, scan_en = 1'b0;
  logic done, pass, fail, scan_out, cen_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdata;

  always #2 clk = ~clk;

  rom_sig_bist #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .RD_LAT(2), .POLY(POLY), .EXP_SIG(GOLD)
  ) i_rom_sig_bist (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .pass_o(pass), .fail_o(fail), .scan_clk_i(scan_clk), .scan_en_i(scan_en),
    .scan_out_o(scan_out), .rom_addr_o(addr), .rom_cen_no(cen_n),
    .rom_data_i(rdata)
  );

  // memory model: capture stage plus output stage
  logic [63:0] mem [DEPTH];
  logic [63:0] rom_st1, rom_q;
  always @(posedge clk) begin
    if (!cen_n) rom_st1 <= mem[addr];
    rom_q <= rom_st1;
  end
  assign rdata = rom_q;

  int total = 0, bad = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] step(input logic [63:0] s, input logic [63:0] d);
    return {s[62:0], 1'b0} ^ (s[63] ? POLY : 64'h0) ^ d;
  endfunction

  // behavioural reference model, updated on each rising edge
  logic        m_cen = 1'b1, m_done = 1'b0, m_pass = 1'b0, m_busy = 1'b0, m_sprev = 1'b0;
  int          m_addr = 0;
  logic [63:0] m_sig = SEED;
  logic        s1_v = 1'b0, s2_v = 1'b0;
  int          s1_a = 0, s2_a = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      logic o_cen, o_busy, o_done;
      int   o_addr;
      o_cen = m_cen; o_addr = m_addr; o_busy = m_busy; o_done = m_done;
      if (s2_v) begin
        m_sig = step(m_sig, mem[s2_a]);
        if (s2_a == DEPTH - 1) begin
          m_done = 1'b1; m_busy = 1'b0; m_pass = (m_sig == GOLD);
        end
      end
      s2_v = s1_v; s2_a = s1_a;
      s1_v = !o_cen; s1_a = o_addr;
      if (scan_clk && !m_sprev && scan_en && o_done) m_sig = m_sig << 1;
      m_sprev = scan_clk;
      if (start && !o_busy) begin
        m_cen = 1'b0; m_addr = 0; m_sig = SEED; m_done = 1'b0; m_pass = 1'b0; m_busy = 1'b1;
      end else if (!o_cen) begin
        if (o_addr == DEPTH - 1) m_cen = 1'b1;
        else m_addr = o_addr + 1;
      end
    end
  end

  logic cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en) begin
      check(64'(cen_n), 64'(m_cen), "R2 enable");
      if (!m_cen) check(64'(addr), 64'(m_addr), "R2 address");
      check(64'(done), 64'(m_done), "R5 done");
      check(64'(pass), 64'(m_done && m_pass), "R6 pass");
      check(64'(fail), 64'(m_done && !m_pass), "R6 fail");
      check(64'(scan_out), 64'(m_sig[63]), "R4 R8 signature msb");
    end
  end

  task automatic build_image();
    logic [63:0] s;
    for (int a = 0; a < DEPTH; a++)
      mem[a] = {32'(a * 32'h9E37_79B1 + 32'h1234), 32'((a ^ 32'h5BD1) * 32'h85EB_CA6B)};
    s = SEED;
    for (int a = 0; a < DEPTH - 1; a++) s = step(s, mem[a]);
    mem[DEPTH-1] = GOLD ^ step(s, 64'h0);
  endtask

  function automatic logic [63:0] image_sig();
    logic [63:0] s = SEED;
    for (int a = 0; a < DEPTH; a++) s = step(s, mem[a]);
    return s;
  endfunction

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic run_test(input int mid_start_at);
    pulse_start();
    for (int c = 0; c < mid_start_at; c++) @(negedge clk);
    if (mid_start_at > 0) pulse_start();
    wait_done();
  endtask

  task automatic scan_all(output logic [63:0] got);
    scan_en = 1'b1;
    for (int b = 63; b >= 0; b--) begin
      got[b] = scan_out;
      scan_clk = 1'b1; @(negedge clk);
      scan_clk = 1'b0; @(negedge clk);
    end
    scan_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [63:0] got, tmp;
    build_image();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(64'(done), 64'h0, "R1 done");
    check(64'(pass | fail), 64'h0, "R1 verdict");
    check(64'(cen_n), 64'h1, "R1 enable");
    check(64'(scan_out), 64'h1, "R1 scan out");
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;

    // golden run, scan strobes during the run must be ignored (R9)
    pulse_start();
    check(64'(cen_n), 64'h0, "R2 first read");
    check(64'(addr), 64'h0, "R2 first address");
    scan_en = 1'b1;
    repeat (4) begin scan_clk = 1'b1; @(negedge clk); scan_clk = 1'b0; @(negedge clk); end
    scan_en = 1'b0;
    wait_done();
    check(64'(pass), 64'h1, "R6 golden image passes");
    check(64'(fail), 64'h0, "R6 golden image no fail");

    // R9: strobes with scan enable low leave the signature unchanged
    repeat (5) begin scan_clk = 1'b1; @(negedge clk); scan_clk = 1'b0; @(negedge clk); end
    scan_all(got);
    check(got, GOLD, "R8 scanned signature");
    check(64'(scan_out), 64'h0, "R8 zero fill after 64 shifts");
    check(64'(pass), 64'h1, "R6 verdict held after scan");

    // R11: restart reseeds and reproduces the result
    run_test(0);
    check(64'(pass), 64'h1, "R11 repeat run passes");
    scan_all(got);
    check(got, image_sig(), "R11 repeat signature");

    // R10: start during a run is ignored
    run_test(150);
    check(64'(pass), 64'h1, "R10 mid-run start ignored");

    // R7: single-bit corruptions
    for (int k = 0; k < 4; k++) begin
      int w, b;
      w = (k == 0) ? 0 : (k == 1) ? DEPTH - 1 : (k == 2) ? 2000 : 777;
      b = (k == 0) ? 0 : (k == 1) ? 63 : (k == 2) ? 17 : 40;
      mem[w][b] = ~mem[w][b];
      run_test(0);
      check(64'(fail), 64'h1, "R7 single bit flip fails");
      scan_all(got);
      check(got, image_sig(), "R7 R4 corrupted signature");
      mem[w][b] = ~mem[w][b];
    end

    // R7: swapped words fail (order dependence)
    tmp = mem[10]; mem[10] = mem[11]; mem[11] = tmp;
    run_test(0);
    check(64'(fail), 64'h1, "R7 swapped words fail");
    tmp = mem[10]; mem[10] = mem[11]; mem[11] = tmp;

    // R3 R11: restored image passes again
    run_test(0);
    check(64'(pass), 64'h1, "R3 R11 restored image passes");

    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule